// File: doc/BRIEF.md
# Big-Endian Sub-Word Memory Lane Unit

A word-organised data store of 64-bit words that serves aligned loads and stores of 1, 2, 4 or 8 bytes. Each byte address is split into a word index (upper bits) and a byte offset (low three bits). Within a word, bytes are numbered big-endian: offset 0 is the most significant byte. A load picks out the addressed lane and returns it right-justified and zero-extended on a registered read port.

A store narrower than a word merges into the word. The current word is read, the target lane is cleared, the new bytes are put in and the result is written back, all in the same clock cycle. A full 8-byte store replaces the word outright. An access whose offset is not a multiple of its width is refused. The store leaves memory untouched, the load returns zero, and an error flag pulses for one cycle. Locations never written since reset read as zero.

Top module: `be_lane_mem`

## Requirements
- R1: After reset, `rd_data` is 0, `misalign_err` is 0, and every word reads as zero until it is stored to.
- R2: The word index is `acc_addr >> 3` and the byte offset is `acc_addr[2:0]`. Distinct word indices, including the first and last word, hold independent values.
- R3: `acc_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An access is legal only when the offset is a multiple of the width. Any access with `rd_en` or `wr_en` high and an illegal offset sets `misalign_err` on the next cycle only, and a legal access or an idle cycle leaves it low.
- R4: Lanes are big-endian. Byte offset k occupies word bits `63-8k` down to `56-8k`, so a lane of w bytes at offset k starts at bit `(8-w-k)*8`.
- R5: A legal 8-byte store replaces the whole word with `wr_data`.
- R6: A legal narrower store changes only its own lane and takes its bytes from the low `8*w` bits of `wr_data`. Higher `wr_data` bits and all other bytes of the word have no effect.
- R7: A legal load updates `rd_data` one cycle after `rd_en` with the lane value, right-justified and zero-extended to 64 bits.
- R8: A misaligned store leaves memory unchanged, and a misaligned load sets `rd_data` to 0.
- R9: `rd_data` holds its value in any cycle in which `rd_en` is low, including store-only cycles.
- R10: With `rd_en` and `wr_en` both high, the load returns the word contents from before the store in that cycle, and the store still takes effect.
- R11: A narrow store into a never-written word produces a word that is zero outside the stored lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Load strobe |
| wr_en | input | 1 | Store strobe |
| acc_addr | input | DEPTH_LOG2+3 | Byte address |
| acc_size | input | 2 | Width code: 0=1B, 1=2B, 2=4B, 3=8B |
| wr_data | input | 64 | Store data, right-justified |
| rd_data | output | 64 | Registered load result, right-justified |
| misalign_err | output | 1 | One-cycle pulse after a misaligned access |

## Verification
A wrong lane shift or byte enable shows on `rd_data` one cycle after the next load of the affected word. Corruption from a narrow-store merge stays hidden until that word is read back, so every narrow store is followed by a full-word load of the same word. A written-word marker that reset does not clear would show as a nonzero value on the first load after a reset. A broken alignment decode shows within one cycle on `misalign_err`, or as a nonzero `rd_data` after a refused load.

// File: rtl/be_lane_pkg.sv
`timescale 1ns/1ps
package be_lane_pkg;
  localparam int LANE_BYTES = 8;
  localparam int OFF_W      = $clog2(LANE_BYTES);
  localparam int WORD_W     = LANE_BYTES * 8;
  localparam int SHAMT_W    = $clog2(WORD_W);

  typedef logic [WORD_W-1:0]     word_t;
  typedef logic [OFF_W-1:0]      off_t;
  typedef logic [SHAMT_W-1:0]    shamt_t;
  typedef logic [LANE_BYTES-1:0] bmask_t;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } size_e;

  // number of bytes covered by a size code
  function automatic logic [OFF_W:0] size_bytes(size_e sz);
    return (OFF_W+1)'(1) << sz;
  endfunction

  // offset must be a multiple of the access width
  function automatic logic lane_aligned(off_t off, size_e sz);
    logic [OFF_W:0] low_bits;
    low_bits = size_bytes(sz) - (OFF_W+1)'(1);
    return (({1'b0, off} & low_bits) == '0);
  endfunction

  // bit position of the lane's least significant bit, big-endian numbering
  function automatic shamt_t lane_shift(off_t off, size_e sz);
    off_t slot;
    slot = OFF_W'((OFF_W+1)'(LANE_BYTES) - size_bytes(sz) - {1'b0, off});
    return {slot, 3'b000};
  endfunction

  // right-justified all-ones mask of the access width
  function automatic word_t lane_mask(size_e sz);
    word_t m;
    m = '0;
    for (int b = 0; b < LANE_BYTES; b++) begin
      if (b < int'(size_bytes(sz))) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  // per-byte enables, bit b = word bits [8b+7:8b]; address byte 0 is bit 7
  function automatic bmask_t lane_bytes(off_t off, size_e sz);
    bmask_t en;
    int lo;
    int hi;
    lo = int'(off);
    hi = lo + int'(size_bytes(sz));
    for (int b = 0; b < LANE_BYTES; b++) begin
      en[b] = ((LANE_BYTES-1-b) >= lo) && ((LANE_BYTES-1-b) < hi);
    end
    return en;
  endfunction

  function automatic word_t place_lane(word_t d, word_t m, shamt_t s);
    return (d & m) << s;
  endfunction

  function automatic word_t pick_lane(word_t w, word_t m, shamt_t s);
    return (w >> s) & m;
  endfunction
endpackage

// File: rtl/be_lane_decode.sv
`timescale 1ns/1ps
module be_lane_decode
  import be_lane_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W+OFF_W-1:0] addr,
  input  size_e                  size,
  output logic [IDX_W-1:0]       idx,
  output shamt_t                 shamt,
  output word_t                  mask,
  output bmask_t                 byte_en,
  output logic                   aligned
);
  off_t off;

  always_comb begin
    idx     = addr[IDX_W+OFF_W-1:OFF_W];
    off     = addr[OFF_W-1:0];
    aligned = lane_aligned(off, size);
    shamt   = lane_shift(off, size);
    mask    = lane_mask(size);
    byte_en = lane_bytes(off, size);
  end
endmodule

// File: rtl/be_lane_merge.sv
`timescale 1ns/1ps
module be_lane_merge
  import be_lane_pkg::*;
(
  input  word_t  old_word,
  input  word_t  wdata,
  input  word_t  mask,
  input  shamt_t shamt,
  input  bmask_t byte_en,
  output word_t  new_word
);
  word_t placed;

  assign placed = place_lane(wdata, mask, shamt);

  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    assign new_word[b*8 +: 8] = byte_en[b] ? placed[b*8 +: 8]
                                           : old_word[b*8 +: 8];
  end
endmodule

// File: rtl/be_lane_extract.sv
`timescale 1ns/1ps
module be_lane_extract
  import be_lane_pkg::*;
(
  input  word_t  word,
  input  word_t  mask,
  input  shamt_t shamt,
  output word_t  value
);
  assign value = pick_lane(word, mask, shamt);
endmodule

// File: rtl/be_word_array.sv
`timescale 1ns/1ps
module be_word_array
  import be_lane_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEPTH_LOG2-1:0] idx,
  output word_t                 rd_word,
  input  logic                  wr_en,
  input  word_t                 wr_word
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  word_t             mem [DEPTH];
  logic [DEPTH-1:0]  live;

  for (genvar w = 0; w < DEPTH; w++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en && (idx == DEPTH_LOG2'(w))) mem[w] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  live[w] <= 1'b0;
      else if (wr_en && (idx == DEPTH_LOG2'(w)))   live[w] <= 1'b1;
    end
  end

  // unwritten rows read as zero
  assign rd_word = live[idx] ? mem[idx] : '0;
endmodule

// File: rtl/be_lane_mem.sv
`timescale 1ns/1ps
module be_lane_mem
  import be_lane_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [DEPTH_LOG2+2:0]   acc_addr,
  input  logic [1:0]              acc_size,
  input  logic [63:0]             wr_data,
  output logic [63:0]             rd_data,
  output logic                    misalign_err
);
  logic [DEPTH_LOG2-1:0] idx;
  shamt_t                shamt;
  word_t                 mask;
  bmask_t                byte_en;
  logic                  aligned;
  word_t                 cur_word;
  word_t                 merged_word;
  word_t                 lane_value;

  // named events for the checker
  logic load_accept;
  logic store_commit;
  logic misalign_hit;

  be_lane_decode #(.IDX_W(DEPTH_LOG2)) u_decode (
    .addr    (acc_addr),
    .size    (size_e'(acc_size)),
    .idx     (idx),
    .shamt   (shamt),
    .mask    (mask),
    .byte_en (byte_en),
    .aligned (aligned)
  );

  be_word_array #(.DEPTH_LOG2(DEPTH_LOG2)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (idx),
    .rd_word (cur_word),
    .wr_en   (store_commit),
    .wr_word (merged_word)
  );

  be_lane_merge u_merge (
    .old_word (cur_word),
    .wdata    (wr_data),
    .mask     (mask),
    .shamt    (shamt),
    .byte_en  (byte_en),
    .new_word (merged_word)
  );

  be_lane_extract u_extract (
    .word  (cur_word),
    .mask  (mask),
    .shamt (shamt),
    .value (lane_value)
  );

  assign load_accept  = rd_en & aligned;
  assign store_commit = wr_en & aligned;
  assign misalign_hit = (rd_en | wr_en) & ~aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      misalign_err <= 1'b0;
    end else begin
      misalign_err <= misalign_hit;
      if (rd_en) rd_data <= load_accept ? lane_value : '0;
    end
  end
endmodule

// File: rtl/be_lane_mem_chk.sv
`timescale 1ns/1ps
module be_lane_mem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [1:0]  acc_size,
  input logic [63:0] rd_data,
  input logic        misalign_err,
  input logic        misalign_hit,
  input logic        store_commit,
  input logic        load_accept
);
  assert_err_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_hit |=> misalign_err);

  assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !misalign_hit |=> !misalign_err);

  assert_load_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $onehot({load_accept, misalign_hit}));

  assert_bad_load_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && misalign_hit) |=> (rd_data == 64'd0));

  assert_bad_store_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && misalign_hit) |-> !store_commit);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_accept && acc_size == 2'd0) |=> (rd_data[63:8] == '0));

  assert_half_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_accept && acc_size == 2'd1) |=> (rd_data[63:16] == '0));

  assert_quad_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_accept && acc_size == 2'd2) |=> (rd_data[63:32] == '0));
endmodule

bind be_lane_mem be_lane_mem_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .acc_size     (acc_size),
  .rd_data      (rd_data),
  .misalign_err (misalign_err),
  .misalign_hit (misalign_hit),
  .store_commit (store_commit),
  .load_accept  (load_accept)
);

// File: tb/tb_be_lane_mem.sv
`timescale 1ns/1ps
module tb_be_lane_mem;
  localparam int DL2 = 8;
  localparam int AW  = DL2 + 3;
  localparam int LAST_BASE = ((1 << DL2) - 1) * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_en, wr_en;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic [63:0]   wr_data;
  logic [63:0]   rd_data;
  logic          misalign_err;

  always #2 clk = ~clk;

  be_lane_mem #(.DEPTH_LOG2(DL2)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .acc_addr(acc_addr), .acc_size(acc_size), .wr_data(wr_data),
    .rd_data(rd_data), .misalign_err(misalign_err)
  );

  // byte-addressed reference: one byte per address, address order = MSB first
  logic [7:0]  bmem [int];
  logic [63:0] last_rd;
  int n_tests = 0;
  int n_fail  = 0;

  // scoreboard queues
  logic [63:0] q_rd  [$];
  logic        q_err [$];
  string       q_tag [$];

  function automatic logic [7:0] mbyte(int a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction

  // driver: one cycle of stimulus, pushes the expected outcome
  task automatic access(bit r, bit w, int a, int sz, logic [63:0] d, string tag);
    int nb;
    bit ok;
    logic [63:0] v;
    @(posedge clk); #1;
    rd_en    = r;
    wr_en    = w;
    acc_addr = AW'(a);
    acc_size = 2'(sz);
    wr_data  = d;
    nb = 1 << sz;
    ok = (a % nb) == 0;
    if (r) begin
      v = '0;
      if (ok) for (int i = 0; i < nb; i++) v = {v[55:0], mbyte(a + i)};
      last_rd = v;
    end
    if (w && ok) for (int i = 0; i < nb; i++) bmem[a + i] = d[8*(nb-1-i) +: 8];
    q_rd.push_back(last_rd);
    q_err.push_back((r || w) && !ok);
    q_tag.push_back(tag);
  endtask

  task automatic idle(string tag);
    access(0, 0, 0, 0, 64'd0, tag);
  endtask

  // monitor: compares one item per cycle, half a nanosecond after the edge
  initial begin
    forever begin
      @(posedge clk); #0.5;
      if (q_rd.size() > 0) begin
        logic [63:0] er;
        logic        ee;
        string       tg;
        er = q_rd.pop_front();
        ee = q_err.pop_front();
        tg = q_tag.pop_front();
        n_tests++;
        if (rd_data !== er) begin
          n_fail++;
          $display("FAIL %s rd_data got %h expected %h", tg, rd_data, er);
        end
        n_tests++;
        if (misalign_err !== ee) begin
          n_fail++;
          $display("FAIL %s misalign_err got %0b expected %0b", tg, misalign_err, ee);
        end
      end
    end
  end

  task automatic check_reset_state(string tag);
    n_tests++;
    if (rd_data !== 64'd0 || misalign_err !== 1'b0) begin
      n_fail++;
      $display("FAIL %s reset outputs got rd=%h err=%0b expected rd=0 err=0",
               tag, rd_data, misalign_err);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    rd_en = 0; wr_en = 0; acc_addr = '0; acc_size = '0; wr_data = '0;
    bmem.delete();
    last_rd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    check_reset_state("R1");
    idle("R1 idle after reset");

    // never-written words
    access(1, 0, 'h40, 3, 0, "R1 unwritten load");
    access(0, 1, 'h45, 0, 64'hFFFF_FFFF_FFFF_FFAB, "R11 narrow store fresh word");
    access(1, 0, 'h40, 3, 0, "R11 fresh word other bytes zero");

    // full-width store and lane reads
    access(0, 1, 'h08, 3, 64'h0123_4567_89AB_CDEF, "R5 full store");
    access(1, 0, 'h08, 3, 0, "R5 full load");
    for (int k = 0; k < 8; k++) access(1, 0, 'h08 + k, 0, 0, "R4 byte lane");
    for (int k = 0; k < 8; k += 2) access(1, 0, 'h08 + k, 1, 0, "R7 half lane");
    for (int k = 0; k < 8; k += 4) access(1, 0, 'h08 + k, 2, 0, "R7 quad lane");

    // narrow read-modify-write stores
    access(0, 1, 'h0B, 0, 64'hFFFF_FFFF_FFFF_FF5A, "R6 byte store");
    access(1, 0, 'h08, 3, 0, "R6 after byte store");
    access(0, 1, 'h0E, 1, 64'h1111_2222_3333_C0DE, "R6 half store");
    access(1, 0, 'h08, 3, 0, "R6 after half store");
    access(0, 1, 'h08, 2, 64'hAAAA_5555_DEAD_BEEF, "R6 quad store");
    access(1, 0, 'h08, 3, 0, "R6 after quad store");
    access(1, 0, 'h0C, 2, 0, "R4 low quad");

    // misaligned accesses
    access(1, 0, 'h09, 1, 0, "R8 bad half load");
    access(0, 1, 'h0A, 2, 64'hFFFF_FFFF_FFFF_FFFF, "R8 bad quad store");
    access(1, 0, 'h08, 3, 0, "R8 word after bad store");
    access(0, 1, 'h0C, 3, 64'h0, "R3 bad full store");
    access(1, 0, 'h0F, 3, 0, "R3 bad full load");
    access(1, 0, 'h0E, 2, 0, "R3 bad quad load");
    access(1, 0, 'h0F, 0, 0, "R3 byte always legal");

    // hold behaviour
    idle("R9 idle hold");
    idle("R9 idle hold");
    access(0, 1, 'h10, 3, 64'h7777_8888_9999_AAAA, "R9 store-only hold");
    idle("R9 idle hold");

    // read and write in the same cycle
    access(1, 1, 'h10, 3, 64'h1357_9BDF_2468_ACE0, "R10 load sees old word");
    access(1, 1, 'h12, 1, 64'h0000_0000_0000_BEEF, "R10 narrow both");
    access(1, 0, 'h10, 3, 0, "R10 store took effect");

    // first and last words are independent
    access(0, 1, LAST_BASE, 3, 64'hFEDC_BA98_7654_3210, "R2 last word store");
    access(0, 1, 0, 3, 64'h0F0F_0F0F_0F0F_0F0F, "R2 first word store");
    access(1, 0, LAST_BASE + 7, 0, 0, "R2 last word byte");
    access(1, 0, 0, 3, 0, "R2 first word");
    access(1, 0, LAST_BASE, 3, 0, "R2 last word");
    idle("R2 drain");
    wait (q_rd.size() == 0);

    // second reset clears every stored word
    do_reset();
    check_reset_state("R1 second reset");
    access(1, 0, 'h08, 3, 0, "R1 word cleared by reset");
    access(1, 0, LAST_BASE, 3, 0, "R1 last word cleared by reset");
    idle("R1 drain");
    idle("R1 drain");
    wait (q_rd.size() == 0);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog all requirements got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule